// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between an execution core and an asynchronous external bus. It takes one operand transfer request at a time. A request is a read or a write of one to four bytes at any byte address. The block turns it into as many external bus cycles as the responder needs.

The block does not know the responder's data width beforehand. Each cycle's two-bit acknowledge reports whether the slave is 8, 16 or 32 bits wide. From that report, the current byte address and the count still outstanding, the block works out how many bytes the cycle moved. It then advances the address and starts the next cycle on the following clock, until nothing is left.

On writes, a lane multiplexer places the outstanding operand bytes on the four byte lanes of the 32-bit data bus. The placement lets a slave of any width find its bytes where it expects them. Byte-lane enables qualify the write. On reads, the bytes are collected from the lanes the responder used and assembled into a right-aligned operand. An instruction prefetch is simply a four-byte read from an address whose two low bits are zero.

Top module: `dbs_seq`

## Requirements
- R1: While reset is asserted and after it is released, no bus cycle is active, `bus_be` is 0, `op_done` and `op_busy` are 0, and `op_rdata` is 0.
- R2: A start seen while idle launches the first bus cycle on the next clock. That cycle is at `op_addr` with `bus_siz` equal to the request size code. The size code is 01 for one byte, 10 for two, 11 for three and 00 for four.
- R3: `bus_ack_n` uses this encoding: 00 means a 32-bit responder, 01 a 16-bit responder, 10 an 8-bit responder, and 11 means no acknowledge yet. With 11, the cycle's address, size code, lanes and enables are held and the cycle repeats.
- R4: An acknowledged cycle moves a number of bytes that depends on the responder width. A 32-bit responder moves min(rem, 4-A[1:0]), a 16-bit responder min(rem, 2-A[0]), and an 8-bit responder one byte. The next cycle's address is higher by that number. Its `bus_siz` is the new remaining count modulo 4.
- R5: On a write, the remaining operand bytes are numbered from the most significant, byte 0 first. With A = A[1:0], D31:24 carries byte 0. D23:16 carries byte 0 if A[0]=1, otherwise byte 1. D15:8 carries byte 2-A when A<=2, otherwise byte 0. D7:0 carries byte 3-A.
- R6: `bus_be[3]` enables D31:24, down to `bus_be[0]` for D7:0. Lane position p (0 for D31:24) is enabled during a write cycle when A <= p < A + rem. During a read cycle all four bits are set, and with no cycle active all are clear.
- R7: On a read, a 32-bit responder supplies byte k of a cycle on lane position A+k, a 16-bit responder on A[0]+k, and an 8-bit responder on D31:24. `op_rdata` holds the operand right-aligned, with the first byte most significant and unused upper bytes zero.
- R8: `op_done` is high for exactly one clock, in the clock after the last acknowledged cycle, with no cycle active. `op_rdata` updates at that point on reads and keeps its previous value on writes.
- R9: A start raised while a transfer is in progress is ignored, and the running transfer completes unchanged.
- R10: `bus_rw` is 1 for a read and 0 for a write, and stays constant for all cycles of one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Request strobe, taken while idle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_size | input | 2 | Byte count code (01/10/11/00 = 1/2/3/4) |
| op_addr | input | AW | Byte address of the operand |
| op_wdata | input | 32 | Write operand, right-aligned |
| op_busy | output | 1 | Transfer in progress |
| op_done | output | 1 | One-clock completion pulse |
| op_rdata | output | 32 | Read operand, right-aligned |
| bus_cyc | output | 1 | Bus cycle active |
| bus_rw | output | 1 | 1 = read cycle |
| bus_addr | output | AW | Cycle byte address |
| bus_siz | output | 2 | Remaining byte count code |
| bus_be | output | 4 | Byte-lane enables, bit 3 = D31:24 |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack_n | input | 2 | Cycle acknowledge / port width, active low |

## Verification
A wrong remaining count or address register shows up on the next bus cycle: `bus_siz` or `bus_addr` departs from the reference, and the cycle count differs from what the responder width and alignment require. A lane steering or gathering fault surfaces at completion, either as a wrong byte in the memory model or as a wrong `op_rdata`. The case analysis covers every combination of port width, size and alignment, so a fault in one corner lands on a specific transfer. Wait states and starts issued mid-transfer exercise the hold and ignore paths, and any disturbance appears in the very next cycle's address or size code.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    ACK_P32  = 2'b00,
    ACK_P16  = 2'b01,
    ACK_P8   = 2'b10,
    ACK_WAIT = 2'b11
  } ack_e;

  // Byte count encoded by a two-bit size code (00 means four).
  function automatic logic [2:0] size_count(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

  // Which outstanding operand byte a write places on lane position p.
  function automatic logic [1:0] wr_src(input int p, input logic [1:0] a);
    logic [1:0] idx;
    case (p)
      0:       idx = 2'd0;
      1:       idx = a[0] ? 2'd0 : 2'd1;
      2:       idx = (a == 2'd3) ? 2'd0 : 2'(2'd2 - a);
      default: idx = 2'(2'd3 - a);
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    ack_n,
  output logic          busy,
  output logic          write,
  output logic [AW-1:0] addr,
  output logic [2:0]    cnt,
  output logic [2:0]    take,
  output logic [1:0]    base,
  output logic          ack_ok,
  output logic          finish,
  output logic          load,
  output logic          done
);

  logic          busy_q, busy_n;
  logic          write_q, write_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [2:0]    cnt_q, cnt_n;
  logic          done_q, done_n;
  logic [2:0]    lim;
  logic [1:0]    a;
  logic          step_en;

  assign a = addr_q[1:0];

  // Bytes this cycle can move, from the responder width and alignment.
  always_comb begin
    lim  = 3'd0;
    base = 2'd0;
    case (ack_n)
      ACK_P32: begin lim = 3'(3'd4 - {1'b0, a}); base = a; end
      ACK_P16: begin lim = 3'(3'd2 - {2'b00, a[0]}); base = {1'b0, a[0]}; end
      ACK_P8:  begin lim = 3'd1; base = 2'd0; end
      default: begin lim = 3'd0; base = 2'd0; end
    endcase
    take = (cnt_q < lim) ? cnt_q : lim;
  end

  assign load    = !busy_q && start;
  assign ack_ok  = busy_q && (ack_n != ACK_WAIT);
  assign finish  = ack_ok && (cnt_q == take);
  assign step_en = load || ack_ok;

  always_comb begin
    busy_n  = busy_q;
    write_n = write_q;
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    done_n  = finish;
    if (load) begin
      busy_n  = 1'b1;
      write_n = req_write;
      addr_n  = req_addr;
      cnt_n   = size_count(req_size);
    end else if (ack_ok) begin
      addr_n = addr_q + AW'(take);
      cnt_n  = cnt_q - take;
      if (finish) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= 3'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      if (step_en) begin
        busy_q  <= busy_n;
        write_q <= write_n;
        addr_q  <= addr_n;
        cnt_q   <= cnt_n;
      end
    end
  end

  assign busy  = busy_q;
  assign write = write_q;
  assign addr  = addr_q;
  assign cnt   = cnt_q;
  assign done  = done_q;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> (busy_q && cnt_q != 3'd0));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ack_n == ACK_WAIT) |=> (busy_q && $stable(addr_q) && $stable(cnt_q)));

  // R4
  cnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !finish) |=> (busy_q && cnt_q < $past(cnt_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/dbs_wsteer.sv
module dbs_wsteer
  import dbs_pkg::*;
(
  input  logic [DW-1:0]    opr,
  input  logic [1:0]       a,
  input  logic [2:0]       cnt,
  input  logic             busy,
  input  logic             write,
  output logic [DW-1:0]    dout,
  output logic [LANES-1:0] be
);

  logic [7:0] rem [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_rem
    assign rem[k] = opr[DW-1-8*k -: 8];
  end

  // Lane position p is bus bits [31-8p : 24-8p].
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic in_win;
    assign dout[DW-1-8*p -: 8] = rem[wr_src(p, a)];
    assign in_win = ({1'b0, a} <= 3'(p)) && (3'(p) < 3'({1'b0, a} + cnt));
    assign be[LANES-1-p] = busy && (!write || in_win);
  end

endmodule

// File: rtl/dbs_gather.sv
module dbs_gather
  import dbs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ack_ok,
  input  logic [2:0]    take,
  input  logic [1:0]    base,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] acc_next
);

  logic [DW-1:0] acc_q;
  logic [DW-1:0] nb;
  logic [7:0]    lane [LANES];
  logic          acc_en;

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign lane[p] = din[DW-1-8*p -: 8];
  end

  // Collect this cycle's bytes in address order, right-aligned.
  always_comb begin
    nb = '0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < take) nb = {nb[DW-9:0], lane[2'(int'(base) + k)]};
    end
  end

  assign acc_en   = load || ack_ok;
  assign acc_next = load ? '0 : ((acc_q << {take, 3'b000}) | nb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_next;
  end

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == '0));

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          op_write,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] op_addr,
  input  logic [31:0]   op_wdata,
  output logic          op_busy,
  output logic          op_done,
  output logic [31:0]   op_rdata,
  output logic          bus_cyc,
  output logic          bus_rw,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic [3:0]    bus_be,
  output logic [31:0]   bus_dout,
  input  logic [31:0]   bus_din,
  input  logic [1:0]    bus_ack_n
);

  logic          busy, write, ack_ok, finish, load, done;
  logic [AW-1:0] addr;
  logic [2:0]    cnt, take;
  logic [1:0]    base;
  logic [DW-1:0] wop_q, wop_n, acc_next;
  logic [DW-1:0] rd_q;
  logic [5:0]    load_sh;
  logic          wop_en, rd_en;

  dbs_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (op_start),
    .req_write (op_write),
    .req_size  (op_size),
    .req_addr  (op_addr),
    .ack_n     (bus_ack_n),
    .busy      (busy),
    .write     (write),
    .addr      (addr),
    .cnt       (cnt),
    .take      (take),
    .base      (base),
    .ack_ok    (ack_ok),
    .finish    (finish),
    .load      (load),
    .done      (done)
  );

  // Outstanding write bytes, left-aligned; shifted out as they are taken.
  assign load_sh = {3'(3'd4 - size_count(op_size)), 3'b000};
  assign wop_en  = load || ack_ok;
  assign wop_n   = load ? (op_wdata << load_sh) : (wop_q << {take, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wop_q <= '0;
    else if (wop_en) wop_q <= wop_n;
  end

  dbs_wsteer u_wsteer (
    .opr   (wop_q),
    .a     (addr[1:0]),
    .cnt   (cnt),
    .busy  (busy),
    .write (write),
    .dout  (bus_dout),
    .be    (bus_be)
  );

  dbs_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ack_ok   (ack_ok),
    .take     (take),
    .base     (base),
    .din      (bus_din),
    .acc_next (acc_next)
  );

  assign rd_en = finish && !write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= acc_next;
  end

  assign op_busy  = busy;
  assign op_done  = done;
  assign op_rdata = rd_q;
  assign bus_cyc  = busy;
  assign bus_rw   = !write;
  assign bus_addr = addr;
  assign bus_siz  = cnt[1:0];

  // R6
  be_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rw) |-> (bus_be != 4'b0000 && $countones(bus_be) <= int'(size_count(bus_siz))));

  // R6
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (bus_be == 4'b0000));

  // R10
  rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> $stable(bus_rw));

endmodule

// File: tb/dbs_seq_tb.sv
module dbs_seq_tb;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_start, op_write;
  logic [1:0]    op_size;
  logic [AW-1:0] op_addr;
  logic [31:0]   op_wdata;
  logic          op_busy, op_done;
  logic [31:0]   op_rdata;
  logic          bus_cyc, bus_rw;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [3:0]    bus_be;
  logic [31:0]   bus_dout, bus_din;
  logic [1:0]    bus_ack_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mem  [0:255];
  logic [7:0] refm [0:255];
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  dbs_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .op_start(op_start), .op_write(op_write), .op_size(op_size),
    .op_addr(op_addr), .op_wdata(op_wdata),
    .op_busy(op_busy), .op_done(op_done), .op_rdata(op_rdata),
    .bus_cyc(bus_cyc), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_be(bus_be), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input bit wr, input logic [1:0] sz, input int ad,
                        input logic [31:0] wd, input int w, input int waits, input bit poke);
    int n, cur, rem, wt, t, lim, bs, guard, p;
    logic [31:0] exp_rd, tmp;
    logic [3:0] ebe;
    bit fin;
    n = (sz == 2'b00) ? 4 : int'(sz);
    exp_rd = 32'h0;
    for (int i = 0; i < n; i++) begin
      exp_rd = (exp_rd << 8) | 32'(mem[ad+i]);
      if (wr) refm[ad+i] = wd[8*(n-1-i) +: 8];
    end
    @(negedge clk);
    op_start = 1'b1; op_write = wr; op_size = sz; op_addr = AW'(ad); op_wdata = wd;
    @(negedge clk);
    op_start = 1'b0;
    cur = ad; rem = n; wt = waits; fin = 0; guard = 0;
    while (!fin && guard < 100) begin
      guard++;
      bus_ack_n = 2'b11;
      bus_din = 32'hA5A5A5A5;
      op_start = 1'b0;
      if (op_done) begin
        fin = 1;
        chk(!bus_cyc, "R8", 32'(bus_cyc), 32'h0);
        if (!wr) begin
          chk(op_rdata == exp_rd, poke ? "R9" : "R7", op_rdata, exp_rd);
          last_rd = exp_rd;
        end else begin
          chk(op_rdata == last_rd, "R8", op_rdata, last_rd);
          for (int i = -1; i <= n; i++)
            chk(mem[ad+i] == refm[ad+i], poke ? "R9" : "R5", 32'(mem[ad+i]), 32'(refm[ad+i]));
        end
        @(negedge clk);
        chk(op_done == 1'b0, "R8", 32'(op_done), 32'h0);
      end else begin
        chk(bus_cyc == 1'b1, "R2", 32'(bus_cyc), 32'h1);
        chk(bus_addr == AW'(cur), "R4", 32'(bus_addr), 32'(cur));
        chk(bus_siz == 2'(rem % 4), "R4", 32'(bus_siz), 32'(rem % 4));
        chk(bus_rw == !wr, "R10", 32'(bus_rw), 32'(!wr));
        ebe = 4'hF;
        if (wr) for (int q = 0; q < 4; q++) ebe[3-q] = (q >= cur % 4) && (q < cur % 4 + rem);
        chk(bus_be == ebe, "R6", 32'(bus_be), 32'(ebe));
        if (wt > 0) begin
          wt--; // R3: cycle must repeat unchanged
          if (poke) begin
            op_start = 1'b1; op_write = !wr; op_size = 2'b00;
            op_addr = AW'(ad ^ 8'h80); op_wdata = ~wd;
          end
        end else begin
          lim = (w == 4) ? 4 - cur % 4 : (w == 2) ? 2 - cur % 2 : 1;
          t   = (rem < lim) ? rem : lim;
          bs  = (w == 4) ? cur % 4 : (w == 2) ? cur % 2 : 0;
          tmp = 32'hA5A5A5A5;
          for (int k = 0; k < t; k++) begin
            p = bs + k;
            if (wr) mem[cur+k] = bus_dout[31-8*p -: 8];
            else    tmp[31-8*p -: 8] = mem[cur+k];
          end
          bus_din   = tmp;
          bus_ack_n = (w == 4) ? 2'b00 : (w == 2) ? 2'b01 : 2'b10;
          cur += t; rem -= t; wt = waits;
        end
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, "R8", 32'h0, 32'h1);
    bus_ack_n = 2'b11;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int idx, ad, w;
    logic [1:0] sz;
    logic [31:0] wd;
    rst_n = 1'b0; op_start = 1'b0; op_write = 1'b0; op_size = 2'b00;
    op_addr = '0; op_wdata = '0; bus_din = '0; bus_ack_n = 2'b11;
    last_rd = 32'h0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 37 + 11);
      refm[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bus_cyc == 1'b0, "R1", 32'(bus_cyc), 32'h0);
    chk(bus_be == 4'h0, "R1", 32'(bus_be), 32'h0);
    chk(op_done == 1'b0, "R1", 32'(op_done), 32'h0);
    chk(op_busy == 1'b0, "R1", 32'(op_busy), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_rdata == 32'h0, "R1", op_rdata, 32'h0);
    chk(bus_cyc == 1'b0, "R1", 32'(bus_cyc), 32'h0);

    idx = 0;
    for (int wi = 0; wi < 3; wi++) begin
      w = (wi == 0) ? 4 : (wi == 1) ? 2 : 1;
      for (int si = 0; si < 4; si++) begin
        sz = (si == 3) ? 2'b00 : 2'(si + 1);
        for (int al = 0; al < 4; al++) begin
          for (int rw = 0; rw < 2; rw++) begin
            ad = 16 + 8 * (idx % 28) + al;
            wd = {8'(idx * 3 + 1), 8'(idx * 5 + 2), 8'(idx * 7 + 3), 8'(idx + 200)};
            run_op(rw == 1, sz, ad, wd, w, idx % 3, 1'b0);
            idx++;
          end
        end
      end
    end
    // R9: starts raised during wait states are ignored
    run_op(1'b0, 2'b00, 8'h31, 32'h0, 1, 2, 1'b1);
    run_op(1'b1, 2'b00, 8'h43, 32'hCAFE1234, 2, 2, 1'b1);
    run_op(1'b1, 2'b10, 8'h55, 32'h0000BEEF, 4, 1, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule